// File: doc/BRIEF.md
# Background Flash Word Streamer

This block moves a linear run of 32-bit words out of a flash memory port and into a two-entry FIFO. It does this in the background, so a DMA engine can collect the words without stalling the processor. Software first programs a word-aligned start address and then a word count. From then on the engine reads one word at a time. It raises a read request only in cycles where the flash port reports idle, so normal execute-in-place fetches are never delayed. Each returned word goes into the FIFO. The address then moves forward by four bytes and the count drops by one. The stream stops when the count reaches zero.

A DMA or a CPU drains the FIFO by reading the data register, and each read removes one word. Writing a count of zero halts a stream at once. Any write to the count register also throws away the data of a read that is still in flight, so a new stream can start straight away. The engine shows its current address and remaining count through the register interface. It drives the FIFO full and empty flags as ports.

Top module: `flash_stream_engine`

## Requirements
- R1: After synchronous reset, the address and count registers read zero, the FIFO is empty and not full, and no flash request is raised.
- R2: The address register at offset 0x14 keeps write data bits 31:2, and its bits 1:0 always read as zero. The flash request address is this register value.
- R3: The FIFO holds two words and never overflows. A request is raised only while the FIFO level plus the outstanding read is below two. The full and empty flags are never both set.
- R4: A flash request is raised only in a cycle where the flash idle input is high and the count is nonzero.
- R5: Each response that is kept pushes its data into the FIFO, adds 4 to the address (with 32-bit wrap) and subtracts 1 from the count. No request is raised once the count is zero.
- R6: Writing zero to the count register at offset 0x18 lowers the request from the next cycle on. The data of a read already in flight is discarded, and the address and FIFO are left unchanged.
- R7: Reading the data register at offset 0x1C returns the oldest stored word and removes it, so words come out in the order they were read from flash.
- R8: Reading the data register while the FIFO is empty returns zero and changes neither the FIFO nor the stream state.
- R9: A pop and a kept response in the same cycle leave the FIFO level unchanged and keep the word order.
- R10: At most one read is outstanding. After a request is granted, no new request is raised until its response has arrived.
- R11: When a count write and a response fall in the same cycle, the written value is kept, the response data is dropped, and the address stays where it was.
- R12: The count register reads its 22 bits in positions 21:0 and zero above them. Write data bits above 21 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe (a read of the data register pops) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of reg_ren |
| fl_idle | input | 1 | Flash port has no other traffic this cycle |
| fl_req | output | 1 | Single-word read request |
| fl_gnt | input | 1 | Request accepted this cycle |
| fl_addr | output | 32 | Byte address of the requested word |
| fl_rvalid | input | 1 | Response data valid strobe |
| fl_rdata | input | 32 | Response data |
| fifo_full | output | 1 | FIFO holds two words |
| fifo_empty | output | 1 | FIFO holds no word |

## Verification
Two pairs of actions can land on the same clock edge. The first pair is a FIFO pop and a response push. The bench provokes it by holding the flash model's reply until one word is already stored, then releasing the reply so that it arrives in the same cycle as a data-register read. It judges the result by the level flags staying at one word and by the two words coming out in order. The second pair is a count write and a response arriving together. The bench lines them up by releasing a held reply and writing the count on the same edge. It then expects an empty FIFO, the written count and an unchanged address.

// File: rtl/fse_pkg.sv
package fse_pkg;

    parameter int STREAM_CNT_W = 22;
    parameter int WORD_W       = 32;
    parameter int WADDR_W      = 30;

    localparam logic [7:0] OFS_ADDR  = 8'h14;
    localparam logic [7:0] OFS_COUNT = 8'h18;
    localparam logic [7:0] OFS_DATA  = 8'h1C;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ADDR,
        SEL_COUNT,
        SEL_DATA
    } rd_sel_e;

    typedef struct packed {
        logic                    addr_wr;
        logic                    cnt_wr;
        logic                    pop;
        logic [WADDR_W-1:0]      waddr;
        logic [STREAM_CNT_W-1:0] wcnt;
    } reg_cmd_t;

    typedef struct packed {
        logic [WADDR_W-1:0]      waddr;
        logic [STREAM_CNT_W-1:0] cnt;
        logic                    busy;
        logic                    drop;
    } seq_state_t;

    function automatic logic [WORD_W-1:0] to_byte_addr(input logic [WADDR_W-1:0] w);
        return {w, 2'b00};
    endfunction

endpackage

// File: rtl/fse_fifo.sv
module fse_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/fse_regif.sv
module fse_regif
    import fse_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                    reg_wen,
    input  logic                    reg_ren,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [WORD_W-1:0]       reg_wdata,
    input  logic [WADDR_W-1:0]      cur_waddr,
    input  logic [STREAM_CNT_W-1:0] cur_cnt,
    input  logic [WORD_W-1:0]       fifo_head,
    input  logic                    fifo_empty,
    output reg_cmd_t                cmd,
    output logic [WORD_W-1:0]       reg_rdata
);

    rd_sel_e sel;

    always_comb begin
        if (reg_addr == ADDR_W'(OFS_ADDR)) begin
            sel = SEL_ADDR;
        end else if (reg_addr == ADDR_W'(OFS_COUNT)) begin
            sel = SEL_COUNT;
        end else if (reg_addr == ADDR_W'(OFS_DATA)) begin
            sel = SEL_DATA;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        cmd.addr_wr = reg_wen && (sel == SEL_ADDR);
        cmd.cnt_wr  = reg_wen && (sel == SEL_COUNT);
        cmd.pop     = reg_ren && (sel == SEL_DATA) && !fifo_empty;
        cmd.waddr   = reg_wdata[WORD_W-1:2];
        cmd.wcnt    = reg_wdata[STREAM_CNT_W-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_ren) begin
            unique case (sel)
                SEL_ADDR:  reg_rdata = to_byte_addr(cur_waddr);
                SEL_COUNT: reg_rdata = WORD_W'(cur_cnt);
                SEL_DATA:  reg_rdata = fifo_empty ? '0 : fifo_head;
                default:   reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/fse_seq.sv
module fse_seq
    import fse_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    addr_wr,
    input  logic                    cnt_wr,
    input  logic [WADDR_W-1:0]      waddr_in,
    input  logic [STREAM_CNT_W-1:0] wcnt_in,
    input  logic [LVL_W-1:0]        fifo_level,
    input  logic                    fl_idle,
    input  logic                    fl_gnt,
    input  logic                    fl_rvalid,
    input  logic [WORD_W-1:0]       fl_rdata,
    output logic                    fl_req,
    output logic [WORD_W-1:0]       fl_addr,
    output logic                    push,
    output logic [WORD_W-1:0]       push_data,
    output logic [WADDR_W-1:0]      cur_waddr,
    output logic [STREAM_CNT_W-1:0] cur_cnt,
    output logic                    busy
);

    seq_state_t st;
    logic       accept;
    logic       keep;
    logic       room;
    logic       issue;

    assign accept = fl_rvalid && st.busy;
    assign keep   = accept && !st.drop && !cnt_wr;
    assign room   = (({1'b0, fifo_level}) + (LVL_W + 1)'(st.busy)) < (LVL_W + 1)'(DEPTH);

    assign fl_req    = fl_idle && (st.cnt != '0) && !st.busy && room && !cnt_wr;
    assign issue     = fl_req && fl_gnt;
    assign fl_addr   = to_byte_addr(st.waddr);
    assign push      = keep;
    assign push_data = fl_rdata;
    assign cur_waddr = st.waddr;
    assign cur_cnt   = st.cnt;
    assign busy      = st.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (addr_wr) begin
                st.waddr <= waddr_in;
            end else if (keep) begin
                st.waddr <= st.waddr + 1'b1;
            end

            if (cnt_wr) begin
                st.cnt <= wcnt_in;
            end else if (keep && st.cnt != '0) begin
                st.cnt <= st.cnt - 1'b1;
            end

            if (issue) begin
                st.busy <= 1'b1;
            end else if (accept) begin
                st.busy <= 1'b0;
            end

            if (accept) begin
                st.drop <= 1'b0;
            end else if (cnt_wr && st.busy) begin
                st.drop <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_stream_engine.sv
module flash_stream_engine
    import fse_pkg::*;
#(
    parameter int FIFO_DEPTH = 2,
    parameter int ADDR_W     = 8,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic              reg_ren,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fl_idle,
    output logic              fl_req,
    input  logic              fl_gnt,
    output logic [31:0]       fl_addr,
    input  logic              fl_rvalid,
    input  logic [31:0]       fl_rdata,
    output logic              fifo_full,
    output logic              fifo_empty
);

    reg_cmd_t                cmd;
    logic [WADDR_W-1:0]      cur_waddr;
    logic [STREAM_CNT_W-1:0] stream_cnt;
    logic                    rd_busy;
    logic                    push;
    logic [WORD_W-1:0]       push_data;
    logic [WORD_W-1:0]       fifo_head;
    logic [LVL_W-1:0]        fifo_level;

    fse_regif #(
        .ADDR_W(ADDR_W)
    ) u_regif (
        .reg_wen   (reg_wen),
        .reg_ren   (reg_ren),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cur_waddr (cur_waddr),
        .cur_cnt   (stream_cnt),
        .fifo_head (fifo_head),
        .fifo_empty(fifo_empty),
        .cmd       (cmd),
        .reg_rdata (reg_rdata)
    );

    fse_seq #(
        .DEPTH(FIFO_DEPTH)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .addr_wr   (cmd.addr_wr),
        .cnt_wr    (cmd.cnt_wr),
        .waddr_in  (cmd.waddr),
        .wcnt_in   (cmd.wcnt),
        .fifo_level(fifo_level),
        .fl_idle   (fl_idle),
        .fl_gnt    (fl_gnt),
        .fl_rvalid (fl_rvalid),
        .fl_rdata  (fl_rdata),
        .fl_req    (fl_req),
        .fl_addr   (fl_addr),
        .push      (push),
        .push_data (push_data),
        .cur_waddr (cur_waddr),
        .cur_cnt   (stream_cnt),
        .busy      (rd_busy)
    );

    fse_fifo #(
        .DEPTH(FIFO_DEPTH),
        .W    (WORD_W)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_data(push_data),
        .pop      (cmd.pop),
        .head     (fifo_head),
        .level    (fifo_level),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

endmodule

// File: rtl/fse_checker.sv
module fse_checker
    import fse_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    reg_wen,
    input logic                    reg_ren,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic [STREAM_CNT_W-1:0] wcnt,
    input logic [31:0]             reg_rdata,
    input logic                    fl_idle,
    input logic                    fl_req,
    input logic                    fl_gnt,
    input logic                    fifo_full,
    input logic                    fifo_empty,
    input logic [STREAM_CNT_W-1:0] stream_cnt,
    input logic                    rd_busy
);

    // R4: request only when the port is idle and words remain
    p_req_needs_idle_r4: assert property (@(posedge clk) disable iff (rst)
        fl_req |-> (fl_idle && stream_cnt != '0));

    // R3: a full FIFO blocks new requests
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !fl_req);

    // R3: level flags are exclusive
    p_flags_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    // R10: a granted request is followed by no request while it is outstanding
    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
        (fl_req && fl_gnt) |=> (rd_busy && !fl_req));

    // R6: a zero count write halts the stream
    p_abort_halts_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && reg_addr == ADDR_W'(OFS_COUNT) && wcnt == '0) |=> (stream_cnt == '0 && !fl_req));

    // R8: empty data read yields zero
    p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_ren && reg_addr == ADDR_W'(OFS_DATA) && fifo_empty) |-> (reg_rdata == '0));

    // R2: low address bits read as zero
    p_addr_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_ren && reg_addr == ADDR_W'(OFS_ADDR)) |-> (reg_rdata[1:0] == 2'b00));

    // R5: a finished stream stays finished until software writes
    p_count_stops_r5: assert property (@(posedge clk) disable iff (rst)
        (stream_cnt == '0 && !reg_wen) |=> (stream_cnt == '0));

endmodule

bind flash_stream_engine fse_checker #(
    .ADDR_W(ADDR_W)
) u_fse_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wen   (reg_wen),
    .reg_ren   (reg_ren),
    .reg_addr  (reg_addr),
    .wcnt      (reg_wdata[fse_pkg::STREAM_CNT_W-1:0]),
    .reg_rdata (reg_rdata),
    .fl_idle   (fl_idle),
    .fl_req    (fl_req),
    .fl_gnt    (fl_gnt),
    .fifo_full (fifo_full),
    .fifo_empty(fifo_empty),
    .stream_cnt(stream_cnt),
    .rd_busy   (rd_busy)
);

// File: tb/sim_flash_stream_engine.sv
module sim_flash_stream_engine;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_ADDR = 8'h14;
    localparam logic [7:0] A_CNT  = 8'h18;
    localparam logic [7:0] A_DATA = 8'h1C;

    // {start address, word count, idle spacing}
    localparam int NVEC = 4;
    localparam logic [47:0] VEC [NVEC] = '{
        {32'h0000_1000, 8'd4, 8'd1},
        {32'h0000_2040, 8'd3, 8'd2},
        {32'hFFFF_FFF8, 8'd3, 8'd1},
        {32'h0ABC_0000, 8'd5, 8'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic        reg_ren = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fl_idle;
    logic        fl_req;
    logic        fl_gnt;
    logic [31:0] fl_addr;
    logic        fl_rvalid;
    logic [31:0] fl_rdata;
    logic        fifo_full;
    logic        fifo_empty;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int idle_mod = 1;
    bit idle_auto = 1'b0;
    bit idle_man = 1'b0;
    bit m_hold = 1'b0;

    logic        m_pend;
    logic [31:0] m_paddr;
    logic [1:0]  m_dly;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) cyc <= cyc + 1;

    assign fl_idle = idle_auto ? ((cyc % idle_mod) == 0) : idle_man;
    assign fl_gnt  = fl_req;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'h3C96_5A0F;
    endfunction

    // flash model: one outstanding read, reply after a short delay unless held
    always @(posedge clk) begin
        fl_rvalid <= 1'b0;
        if (rst) begin
            m_pend <= 1'b0;
            m_dly  <= '0;
        end else if (m_pend) begin
            if (m_dly != 0) begin
                m_dly <= m_dly - 1'b1;
            end else if (!m_hold) begin
                fl_rvalid <= 1'b1;
                fl_rdata  <= pat(m_paddr);
                m_pend    <= 1'b0;
            end
        end else if (fl_req && fl_gnt) begin
            m_pend  <= 1'b1;
            m_paddr <= fl_addr;
            m_dly   <= 2'd1;
        end
    end

    flash_stream_engine u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_wen   (reg_wen),
        .reg_ren   (reg_ren),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fl_idle   (fl_idle),
        .fl_req    (fl_req),
        .fl_gnt    (fl_gnt),
        .fl_addr   (fl_addr),
        .fl_rvalid (fl_rvalid),
        .fl_rdata  (fl_rdata),
        .fifo_full (fifo_full),
        .fifo_empty(fifo_empty)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wen   = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_ren  = 1'b1;
        reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_ren  = 1'b0;
    endtask

    task automatic wait_data(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (!fifo_empty) begin
                ok = 1'b1;
                return;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit          ok;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        #1;
        chk("R1 empty", 32'(fifo_empty), 32'd1);
        chk("R1 full", 32'(fifo_full), 32'd0);
        chk("R1 req", 32'(fl_req), 32'd0);
        rd(A_ADDR, d); chk("R1 addr", d, 32'h0);
        rd(A_CNT, d);  chk("R1 count", d, 32'h0);

        // R2: low address bits dropped
        wr(A_ADDR, 32'h1234_5677);
        rd(A_ADDR, d); chk("R2 addr low bits", d, 32'h1234_5674);

        // R12: count field width
        idle_man = 1'b0;
        wr(A_CNT, 32'hFFC0_0005);
        rd(A_CNT, d); chk("R12 count width", d, 32'h0000_0005);
        wr(A_CNT, 32'h0);

        // R8: empty read
        rd(A_DATA, d); chk("R8 empty data", d, 32'h0);
        #1;
        chk("R8 still empty", 32'(fifo_empty), 32'd1);
        rd(A_ADDR, d); chk("R8 addr kept", d, 32'h1234_5674);
        rd(A_CNT, d);  chk("R8 count kept", d, 32'h0);

        // R5 / R7: table of streams under different idle spacing
        idle_auto = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] a0;
            int          n;
            a0       = VEC[v][47:16];
            n        = int'(VEC[v][15:8]);
            idle_mod = int'(VEC[v][7:0]);
            wr(A_ADDR, a0);
            wr(A_CNT, 32'(n));
            for (int i = 0; i < n; i++) begin
                wait_data(ok);
                chk("R5 word arrived", 32'(ok), 32'd1);
                rd(A_DATA, d);
                chk("R7 word order", d, pat(a0 + 32'(4 * i)));
            end
            repeat (4) @(negedge clk);
            rd(A_ADDR, d); chk("R5 final addr", d, a0 + 32'(4 * n));
            rd(A_CNT, d);  chk("R5 final count", d, 32'h0);
            #1;
            chk("R5 no req at zero", 32'(fl_req), 32'd0);
            chk("R5 fifo drained", 32'(fifo_empty), 32'd1);
        end
        idle_auto = 1'b0;
        idle_mod  = 1;

        // R3: fill without popping
        idle_man = 1'b1;
        wr(A_ADDR, 32'h0000_4000);
        wr(A_CNT, 32'd5);
        repeat (20) @(negedge clk);
        #1;
        chk("R3 full", 32'(fifo_full), 32'd1);
        chk("R3 not empty", 32'(fifo_empty), 32'd0);
        chk("R3 req blocked", 32'(fl_req), 32'd0);
        rd(A_CNT, d);  chk("R3 count held", d, 32'd3);
        rd(A_ADDR, d); chk("R3 addr held", d, 32'h0000_4008);
        rd(A_DATA, d); chk("R3 first", d, pat(32'h0000_4000));
        rd(A_DATA, d); chk("R3 second", d, pat(32'h0000_4004));
        for (int i = 2; i < 5; i++) begin
            wait_data(ok);
            rd(A_DATA, d);
            chk("R3 rest", d, pat(32'h0000_4000 + 32'(4 * i)));
        end
        repeat (4) @(negedge clk);

        // R4 / R10 / R6: abort with a read in flight
        idle_man = 1'b0;
        m_hold   = 1'b1;
        wr(A_ADDR, 32'h0000_3000);
        wr(A_CNT, 32'd3);
        repeat (3) @(negedge clk);
        #1;
        chk("R4 no req when busy port", 32'(fl_req), 32'd0);
        idle_man = 1'b1;
        #1;
        chk("R4 req when idle", 32'(fl_req), 32'd1);
        chk("R2 request address", fl_addr, 32'h0000_3000);
        @(negedge clk);
        #1;
        chk("R10 no second req", 32'(fl_req), 32'd0);
        wr(A_CNT, 32'h0);
        #1;
        chk("R6 req low", 32'(fl_req), 32'd0);
        m_hold = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        chk("R6 data dropped", 32'(fifo_empty), 32'd1);
        chk("R6 still halted", 32'(fl_req), 32'd0);
        rd(A_ADDR, d); chk("R6 addr unchanged", d, 32'h0000_3000);
        rd(A_CNT, d);  chk("R6 count zero", d, 32'h0);

        // R9: pop and push in the same cycle
        idle_man = 1'b0;
        m_hold   = 1'b1;
        wr(A_ADDR, 32'h0000_5000);
        wr(A_CNT, 32'd2);
        idle_man = 1'b1;
        @(negedge clk);
        repeat (2) @(negedge clk);
        m_hold = 1'b0;
        @(negedge clk);
        m_hold = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R9 one stored", 32'(fifo_empty), 32'd0);
        repeat (2) @(negedge clk);
        m_hold = 1'b0;
        @(negedge clk);
        rd(A_DATA, d); chk("R9 head during push", d, pat(32'h0000_5000));
        #1;
        chk("R9 level kept not empty", 32'(fifo_empty), 32'd0);
        chk("R9 level kept not full", 32'(fifo_full), 32'd0);
        rd(A_DATA, d); chk("R9 second word", d, pat(32'h0000_5004));
        #1;
        chk("R9 now empty", 32'(fifo_empty), 32'd1);
        rd(A_ADDR, d); chk("R9 addr", d, 32'h0000_5008);
        rd(A_CNT, d);  chk("R9 count", d, 32'h0);

        // R11: count write meets a response
        idle_man = 1'b0;
        m_hold   = 1'b1;
        wr(A_ADDR, 32'h0000_6000);
        wr(A_CNT, 32'd4);
        idle_man = 1'b1;
        @(negedge clk);
        idle_man = 1'b0;
        repeat (2) @(negedge clk);
        m_hold = 1'b0;
        @(negedge clk);
        wr(A_CNT, 32'd3);
        repeat (3) @(negedge clk);
        #1;
        chk("R11 response dropped", 32'(fifo_empty), 32'd1);
        rd(A_CNT, d);  chk("R11 written count kept", d, 32'd3);
        rd(A_ADDR, d); chk("R11 addr unchanged", d, 32'h0000_6000);
        wr(A_CNT, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule